// File: doc/BRIEF.md
# Multiport DRAM Cycle Decoder

This block watches the row, column, write, transfer and serial-enable strobes of a dual-port video DRAM. It does so in a clocked model in which every strobe is a level sampled on the system clock. When the row strobe falls, it captures the strobe levels and the address. When the row strobe rises again, it names the kind of memory cycle that just ran with a single one-clock flag. The kinds are a plain write, a masked write, three kinds of transfer between the array and the serial register, a row-only refresh, a column-before-row refresh, and a refresh that also loads a logic-operation code.

When the row strobe falls, the block also issues side strobes. It loads the per-bit write mask for array cycles and fires a transfer request towards the serial port. For the logic-set cycle it loads the logic code. Both refresh variants that start with the column strobe already low take their row from an internal 8-bit refresh counter, and that counter advances once each such cycle ends.

Top module: `vdr_cycle_decoder`

## Requirements
- R1: After reset, `cyc_flags`, `mask_load`, `xfer_go` and `logic_load` are 0, and the refresh counter holds row 0.
- R2: Each row-strobe low period produces exactly one flag in `cyc_flags`. The flag is a single-clock pulse, visible in the clock after the rising edge of `ras_n` is sampled. Bit positions: 0 plain write, 1 masked write, 2 read transfer, 3 write transfer, 4 pseudo transfer, 5 row-only refresh, 6 column-before-row refresh, 7 logic set.
- R3: When `cas_n` is low at the row-strobe fall and `we_n` is high, the cycle is a column-before-row refresh (bit 6). In that case `row_addr` takes the refresh counter value rather than `addr`.
- R4: When `cas_n` and `we_n` are both low at the row-strobe fall, the cycle is a logic set (bit 7). It pulses `logic_load` one clock after the fall with `logic_code` = `addr[3:0]`, and it refreshes the counter's row like R3.
- R5: The refresh counter advances by one after each cycle of the R3 or R4 kind, wraps from 255 to 0, and holds during every other cycle.
- R6: With `cas_n` high and `dt_n` low at the fall, the cycle is a transfer, and `xfer_go` pulses one clock after the fall. With `we_n` high the transfer is a read transfer (bit 2).
- R7: A transfer with `we_n` low is a write transfer (bit 3) when `se_n` is low, and a pseudo transfer (bit 4) when `se_n` is high.
- R8: For a cycle with `cas_n` and `dt_n` high at the fall, `mask_load` pulses one clock after the fall. With `we_n` low, `wr_mask` takes the `dq_in` levels, where 1 enables writing the bit and 0 masks it. If `cas_n` falls later in the cycle, the flag is bit 1.
- R9: For the same kind of cycle with `we_n` high, `wr_mask` becomes all ones, and the flag is bit 0 if `cas_n` falls later.
- R10: A cycle with `cas_n`, `dt_n` high at the fall in which `cas_n` never goes low before the row strobe rises is a row-only refresh (bit 5), and the refresh counter does not move.
- R11: `row_addr` is loaded only at a row-strobe fall and holds through the cycle, whatever `addr`, `dq_in` and the control strobes do after the fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe level, active low |
| cas_n | input | 1 | Column strobe level, active low |
| we_n | input | 1 | Write enable level, active low |
| dt_n | input | 1 | Transfer / output-enable level, active low |
| se_n | input | 1 | Serial-port enable level, active low |
| addr | input | 8 | Multiplexed address |
| dq_in | input | 4 | Data pin levels, used as mask bits at the fall |
| cyc_flags | output | 8 | One-hot cycle kind, one-clock pulse at cycle end |
| row_addr | output | 8 | Latched row (external or refresh counter) |
| wr_mask | output | 4 | Per-bit write enable latched at the fall |
| mask_load | output | 1 | Pulse: write mask reloaded |
| xfer_go | output | 1 | Pulse: transfer requested towards serial port |
| logic_load | output | 1 | Pulse: logic code loaded |
| logic_code | output | 4 | Latched logic-operation code |

## Verification
Directed cycles cover every combination of strobe levels that selects a distinct kind: column strobe early or late, transfer strobe low with each write and serial-enable level, and the array cycle with the column strobe present or absent. Mask patterns 1010 and 0101 against an all-ones plain write show that the mask comes from the data pins and the write-enable level, and not from a fixed value. Every cycle moves the address and strobes after the fall, which separates levels captured at the fall from live levels. A run of 256 counter-based refreshes, with row-only refreshes placed between them, shows the wrap and shows that the counter moves only on the counter-based cycles.

// File: rtl/vdr_pkg.sv
package vdr_pkg;
  localparam int unsigned CYC_W = 8;

  typedef enum logic [2:0] {
    CY_PLAIN_WR  = 3'd0,
    CY_MASK_WR   = 3'd1,
    CY_RD_XFER   = 3'd2,
    CY_WR_XFER   = 3'd3,
    CY_PSEUDO    = 3'd4,
    CY_ROW_REF   = 3'd5,
    CY_CBR_REF   = 3'd6,
    CY_LOGIC_SET = 3'd7
  } cyc_e;

  typedef struct packed {
    logic cas_lo;
    logic we_lo;
    logic dt_lo;
    logic se_lo;
  } strobe_t;
endpackage

// File: rtl/vdr_strobe_sampler.sv
module vdr_strobe_sampler
  import vdr_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ras_n,
  input  logic    cas_n,
  input  strobe_t live,
  output logic    ras_fall,
  output logic    ras_rise,
  output strobe_t held,
  output logic    cas_seen
);
  logic    ras_q;
  logic    seen_q, seen_d;
  strobe_t held_d;

  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_seen = seen_q | ~cas_n;

  always_comb begin
    held_d = held;
    seen_d = seen_q;
    if (ras_fall) begin
      held_d = live;
      seen_d = 1'b0;
    end else if (~ras_q & ~ras_n & ~cas_n) begin
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q  <= 1'b1;
      held   <= '0;
      seen_q <= 1'b0;
    end else begin
      ras_q  <= ras_n;
      held   <= held_d;
      seen_q <= seen_d;
    end
  end

  AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_fall |=> $stable(held)); // R11
endmodule

// File: rtl/vdr_cycle_classify.sv
module vdr_cycle_classify
  import vdr_pkg::*;
(
  input  strobe_t lvl,
  input  logic    cas_seen,
  output cyc_e    kind
);
  always_comb begin
    if (lvl.cas_lo)
      kind = lvl.we_lo ? CY_LOGIC_SET : CY_CBR_REF;
    else if (lvl.dt_lo)
      kind = !lvl.we_lo ? CY_RD_XFER : (lvl.se_lo ? CY_WR_XFER : CY_PSEUDO);
    else if (!cas_seen)
      kind = CY_ROW_REF;
    else
      kind = lvl.we_lo ? CY_MASK_WR : CY_PLAIN_WR;
  end
endmodule

// File: rtl/vdr_refresh_ctr.sv
module vdr_refresh_ctr #(
  parameter int unsigned RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [RW-1:0] cnt
);
  logic [RW-1:0] cnt_d;

  always_comb cnt_d = adv ? cnt + 1'b1 : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(adv) |-> cnt == RW'($past(cnt) + 1'b1)); // R5
  AST_CTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(adv) |-> $stable(cnt)); // R5
endmodule

// File: rtl/vdr_cycle_decoder.sv
module vdr_cycle_decoder
  import vdr_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DQ_W   = 4,
  parameter int unsigned CODE_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic                dt_n,
  input  logic                se_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DQ_W-1:0]     dq_in,
  output logic [CYC_W-1:0]    cyc_flags,
  output logic [ADDR_W-1:0]   row_addr,
  output logic [DQ_W-1:0]     wr_mask,
  output logic                mask_load,
  output logic                xfer_go,
  output logic                logic_load,
  output logic [CODE_W-1:0]   logic_code
);
  localparam int unsigned RW = ADDR_W;

  strobe_t       live, held;
  logic          ras_fall, ras_rise, cas_seen;
  cyc_e          kind_now, kind_end;
  logic [RW-1:0] ref_row;
  logic          adv;
  logic          now_counter, now_xfer, now_array;

  logic [CYC_W-1:0]  flags_d;
  logic [ADDR_W-1:0] row_d;
  logic [DQ_W-1:0]   mask_d;
  logic [CODE_W-1:0] code_d;
  logic              mld_d, xfer_d, lld_d;

  assign live = '{cas_lo: ~cas_n, we_lo: ~we_n, dt_lo: ~dt_n, se_lo: ~se_n};

  vdr_strobe_sampler u_samp (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .live(live),
    .ras_fall(ras_fall), .ras_rise(ras_rise), .held(held), .cas_seen(cas_seen)
  );

  // classification of the levels present right at the fall
  vdr_cycle_classify u_cls_now (.lvl(live), .cas_seen(1'b1), .kind(kind_now));
  // final classification once the cycle has ended
  vdr_cycle_classify u_cls_end (.lvl(held), .cas_seen(cas_seen), .kind(kind_end));

  vdr_refresh_ctr #(.RW(RW)) u_ref (
    .clk(clk), .rst_n(rst_n), .adv(adv), .cnt(ref_row)
  );

  assign now_counter = (kind_now == CY_CBR_REF) || (kind_now == CY_LOGIC_SET);
  assign now_xfer    = (kind_now == CY_RD_XFER) || (kind_now == CY_WR_XFER) ||
                       (kind_now == CY_PSEUDO);
  assign now_array   = (kind_now == CY_PLAIN_WR) || (kind_now == CY_MASK_WR);
  assign adv = ras_rise && ((kind_end == CY_CBR_REF) || (kind_end == CY_LOGIC_SET));

  always_comb begin
    flags_d = ras_rise ? (CYC_W'(1) << kind_end) : '0;
    row_d   = row_addr;
    mask_d  = wr_mask;
    code_d  = logic_code;
    mld_d   = ras_fall & now_array;
    xfer_d  = ras_fall & now_xfer;
    lld_d   = ras_fall & (kind_now == CY_LOGIC_SET);
    if (ras_fall) row_d = now_counter ? ref_row : addr;
    if (mld_d)    mask_d = live.we_lo ? dq_in : '1;
    if (lld_d)    code_d = addr[CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_flags  <= '0;
      row_addr   <= '0;
      wr_mask    <= '1;
      mask_load  <= 1'b0;
      xfer_go    <= 1'b0;
      logic_load <= 1'b0;
      logic_code <= '0;
    end else begin
      cyc_flags  <= flags_d;
      row_addr   <= row_d;
      wr_mask    <= mask_d;
      mask_load  <= mld_d;
      xfer_go    <= xfer_d;
      logic_load <= lld_d;
      logic_code <= code_d;
    end
  end

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cyc_flags)); // R2
  AST_FLAG_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (|cyc_flags) |-> ($past(ras_n) && !$past(ras_n, 2))); // R2
  AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mask_load, xfer_go, logic_load})); // R6
  AST_MASK_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_load && $past(we_n)) |-> (wr_mask == '1)); // R9
endmodule

// File: tb/vdr_cycle_decoder_tb.sv
module vdr_cycle_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ras_n, cas_n, we_n, dt_n, se_n;
  logic [7:0] addr;
  logic [3:0] dq_in;
  logic [7:0] cyc_flags, row_addr;
  logic [3:0] wr_mask, logic_code;
  logic       mask_load, xfer_go, logic_load;

  int total = 0;
  int bad   = 0;
  int ref_cnt = 0;

  logic [7:0] c_fl_fall, c_row, c_fl, c_row_end, c_fl_after;
  logic [3:0] c_mask, c_code;
  logic       c_mld, c_xf, c_lld;

  always #(CLK_PERIOD/2) clk = ~clk;

  vdr_cycle_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dt_n(dt_n), .se_n(se_n), .addr(addr), .dq_in(dq_in),
    .cyc_flags(cyc_flags), .row_addr(row_addr), .wr_mask(wr_mask),
    .mask_load(mask_load), .xfer_go(xfer_go), .logic_load(logic_load),
    .logic_code(logic_code)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one row-strobe period; levels given are those at the fall
  task automatic run_cyc(input bit early, input bit we, input bit dt, input bit se,
                         input logic [3:0] io, input logic [7:0] a, input bit late);
    @(negedge clk);
    ras_n = 1'b1; cas_n = early ? 1'b0 : 1'b1;
    we_n = we; dt_n = dt; se_n = se; dq_in = io; addr = a;
    @(negedge clk);
    ras_n = 1'b0;
    @(negedge clk);
    c_fl_fall = cyc_flags; c_row = row_addr; c_mask = wr_mask; c_mld = mask_load;
    c_xf = xfer_go; c_lld = logic_load; c_code = logic_code;
    addr = ~a; dq_in = ~io; we_n = 1'b1; dt_n = 1'b1; se_n = ~se;
    cas_n = (early || late) ? 1'b0 : 1'b1;
    @(negedge clk);
    ras_n = 1'b1;
    @(negedge clk);
    c_fl = cyc_flags; c_row_end = row_addr;
    cas_n = 1'b1;
    @(negedge clk);
    c_fl_after = cyc_flags;
  endtask

  task automatic common(input string req, input int bitpos, input int row_exp);
    check(req, "no flag at fall", c_fl_fall, 0);
    check(req, "flag", c_fl, 1 << bitpos);
    check("R2", "flag pulse cleared", c_fl_after, 0);
    check(req, "row at fall", c_row, row_exp);
    check("R11", "row held", c_row_end, row_exp);
  endtask

  task automatic t_reset();
    check("R1", "flags", cyc_flags, 0);
    check("R1", "mask_load", mask_load, 0);
    check("R1", "xfer_go", xfer_go, 0);
    check("R1", "logic_load", logic_load, 0);
  endtask

  task automatic t_plain();
    run_cyc(0, 1, 1, 1, 4'h0, 8'h5A, 1);
    common("R9", 0, 8'h5A);
    check("R9", "mask_load", c_mld, 1);
    check("R9", "mask all on", c_mask, 4'hF);
    check("R9", "no xfer", c_xf, 0);
  endtask

  task automatic t_masked(input logic [3:0] io);
    run_cyc(0, 0, 1, 1, io, 8'hC3, 1);
    common("R8", 1, 8'hC3);
    check("R8", "mask_load", c_mld, 1);
    check("R8", "mask from pins", c_mask, io);
  endtask

  task automatic t_row_ref();
    run_cyc(0, 1, 1, 1, 4'h0, 8'h77, 0);
    common("R10", 5, 8'h77);
  endtask

  task automatic t_xfer(input bit we, input bit se, input int bitpos, input string req);
    run_cyc(0, we, 0, se, 4'h3, 8'h19, 1);
    common(req, bitpos, 8'h19);
    check("R6", "xfer_go", c_xf, 1);
    check(req, "no mask_load", c_mld, 0);
  endtask

  task automatic t_cbr(input string req);
    run_cyc(1, 1, 1, 1, 4'h0, 8'hE1, 0);
    common(req, 6, ref_cnt);
    check("R3", "no logic_load", c_lld, 0);
    check("R3", "no mask_load", c_mld, 0);
    ref_cnt = (ref_cnt + 1) % 256;
  endtask

  task automatic t_logic();
    run_cyc(1, 0, 1, 1, 4'h6, 8'h3C, 0);
    common("R4", 7, ref_cnt);
    check("R4", "logic_load", c_lld, 1);
    check("R4", "logic code", c_code, 4'hC);
    ref_cnt = (ref_cnt + 1) % 256;
  endtask

  task automatic t_wrap();
    while (ref_cnt != 255) begin
      run_cyc(1, 1, 1, 1, 4'h0, 8'h00, 0);
      ref_cnt++;
    end
    t_cbr("R5");
    check("R5", "wrapped", ref_cnt, 0);
    t_row_ref();
    t_cbr("R5");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; dt_n = 1'b1;
    se_n = 1'b1; addr = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cbr("R1");        // first counter refresh must use row 0
    t_plain();
    t_masked(4'b1010);
    t_masked(4'b0101);
    t_row_ref();
    t_cbr("R3");        // counter unchanged by the row-only refresh
    t_xfer(1, 1, 2, "R6");
    t_xfer(0, 0, 3, "R7");
    t_xfer(0, 1, 4, "R7");
    t_logic();
    t_cbr("R5");
    t_wrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule